// File: doc/BRIEF.md
# Byte-Addressed I2C Target Memory

This block is a 256-byte memory that answers as a target device on a two-wire serial bus. It sees the clock and data lines only through synchronised, oversampled copies taken in its own system clock domain. It drives the data line through a single pull-down enable, so the data wire is meant to be open drain with an external pull-up. A controller on the bus opens a transfer with a start condition and sends a 7-bit device address plus a direction bit. If the address matches the block's parameter address, the block acknowledges it.

In a write, the first byte after the address loads an internal word pointer. Each later byte is stored at the pointer, and the pointer then advances inside the current aligned 8-byte page. In a read, the controller first writes the word pointer, then issues a repeated start and the same address with the read bit set. The block then returns stored bytes starting at the pointer, for as long as the controller acknowledges each byte. A read with no preceding pointer write continues from wherever the pointer was left.

The system clock must run at least 8 times faster than the bus clock. The block does not stretch the bus clock and does not answer a general call.

Top module: `i2cRegMem`

## Requirements
- R1: A falling data line while the synchronised clock line is high is a start condition. From any state it releases the data line and begins a fresh 8-bit address phase, even in the middle of a byte.
- R2: A rising data line while the clock line is high is a stop condition. It releases the data line and ends the transfer. Bits clocked after a stop and before the next start get no acknowledge and store nothing.
- R3: After a start, 8 bits are taken most significant bit first, each sampled on a rising clock edge. Bits [7:1] are compared with DEV_ADDR (default 7'h50), and bit 0 is the direction (1 = read). On a match the block pulls the data line low for the whole ninth clock. On a mismatch it leaves the line released and ignores every bit until the next start.
- R4: In a write transfer, the first byte after the address loads the word pointer. Every complete received byte, including that one, is acknowledged by pulling the data line low during the ninth clock.
- R5: Each data byte after the pointer byte is stored at the pointer. The pointer's low 3 bits then increment modulo 8 while its upper bits stay fixed, so a ninth byte in one burst overwrites the first location written in that page.
- R6: After a matching address with the read bit set, the block sends the byte at the pointer, most significant bit first. It changes the data line only after a falling clock edge. The pointer then advances by 1 modulo 256, crossing page boundaries.
- R7: A controller acknowledge (data low on the ninth clock of a read byte) makes the block send the next byte. A not-acknowledge makes it release the data line and stay released until the next start or stop.
- R8: While reset is held and after it is released, the data line is released.
- R9: The pull-down enable changes only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen on the wire |
| sdaIn | input | 1 | Bus data line as seen on the wire |
| sdaPullLow | output | 1 | 1 = pull the data line low, 0 = release it |

## Verification
Writes are tried with a short burst, a full page plus one byte that starts page-aligned, and a burst that starts near the end of a page. Together these separate a plain incrementing pointer from the page-wrapping one. Reads are tried as a repeated-start read that runs over a page boundary, and as a current-address read with no pointer byte. These show that read advance is linear and that the pointer keeps its value between transfers. The negative patterns are a foreign address, bits clocked after a stop, and a start cut into the middle of a byte. They show that no acknowledge and no store happens outside a valid frame, and that a start always resynchronises the bit count.

// File: rtl/i2cMemPkg.sv
package i2cMemPkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RD_ACK
  } slvState_t;

  // Strobes from the control FSM to the datapath, one cycle wide each.
  typedef struct packed {
    logic shiftIn;    // take the synchronised data bit into the receive shifter
    logic setPtr;     // load the word pointer from the received byte
    logic writeByte;  // store the received byte, advance within the page
    logic loadTx;     // fetch the byte at the pointer, advance linearly
    logic shiftTx;    // present the next transmit bit
  } pathStb_t;

endpackage

// File: rtl/i2cBusSense.sv
module i2cBusSense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

endmodule

// File: rtl/i2cMemPath.sv
module i2cMemPath
  import i2cMemPkg::*;
#(
  parameter int MEM_DEPTH  = 256,
  parameter int PAGE_BYTES = 8,
  localparam int ADDR_W    = $clog2(MEM_DEPTH),
  localparam int PAGE_BITS = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStb_t          stb,
  input  logic              sdaS,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic [ADDR_W-1:0] wordPtr
);

  logic [BYTE_W-1:0] memArr [MEM_DEPTH];
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic [ADDR_W-1:0] ptrQ;
  logic [ADDR_W-1:0] ptrPageNext;

  assign ptrPageNext = {ptrQ[ADDR_W-1:PAGE_BITS],
                        ptrQ[PAGE_BITS-1:0] + PAGE_BITS'(1)};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      ptrQ    <= '0;
    end else begin
      if (stb.shiftIn)   rxShift <= {rxShift[BYTE_W-2:0], sdaS};
      if (stb.shiftTx)   txShift <= {txShift[BYTE_W-2:0], 1'b1};
      if (stb.setPtr)    ptrQ    <= ADDR_W'(rxShift);
      if (stb.writeByte) ptrQ    <= ptrPageNext;
      if (stb.loadTx) begin
        txShift <= memArr[ptrQ];
        ptrQ    <= ptrQ + ADDR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.writeByte) memArr[ptrQ] <= rxShift;
  end

  assign rxByte  = rxShift;
  assign txMsb   = txShift[BYTE_W-1];
  assign wordPtr = ptrQ;

endmodule

// File: rtl/i2cSlaveCtrl.sv
module i2cSlaveCtrl
  import i2cMemPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sdaS,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  output pathStb_t          stb,
  output logic              sdaPullLow
);

  slvState_t state, stateNxt;
  logic [3:0] bitCnt, bitCntNxt;
  logic       rwBit, rwBitNxt;
  logic       masterAck, masterAckNxt;
  logic       rxState;
  logic       ackState;

  assign rxState  = (state == ST_ADDR) || (state == ST_WADDR) || (state == ST_WDATA);
  assign ackState = (state == ST_ADDR_ACK) || (state == ST_WADDR_ACK) ||
                    (state == ST_WDATA_ACK);

  always_comb begin
    stb          = '0;
    stateNxt     = state;
    bitCntNxt    = bitCnt;
    rwBitNxt     = rwBit;
    masterAckNxt = masterAck;
    if (startDet) begin
      stateNxt  = ST_ADDR;
      bitCntNxt = '0;
    end else if (stopDet) begin
      stateNxt  = ST_IDLE;
      bitCntNxt = '0;
    end else if (rxState) begin
      if (sclRise && bitCnt < 4'd8) begin
        stb.shiftIn = 1'b1;
        bitCntNxt   = bitCnt + 4'd1;
      end
      if (sclFall && bitCnt == 4'd8) begin
        bitCntNxt = '0;
        unique case (state)
          ST_ADDR: begin
            if (rxByte[7:1] == DEV_ADDR) begin
              stateNxt = ST_ADDR_ACK;
              rwBitNxt = rxByte[0];
            end else begin
              stateNxt = ST_IDLE;
            end
          end
          ST_WADDR: begin
            stb.setPtr = 1'b1;
            stateNxt   = ST_WADDR_ACK;
          end
          default: begin
            stb.writeByte = 1'b1;
            stateNxt      = ST_WDATA_ACK;
          end
        endcase
      end
    end else begin
      unique case (state)
        ST_ADDR_ACK: begin
          if (sclFall) begin
            bitCntNxt = '0;
            if (rwBit) begin
              stb.loadTx = 1'b1;
              stateNxt   = ST_RDATA;
            end else begin
              stateNxt = ST_WADDR;
            end
          end
        end
        ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (sclFall) begin
            bitCntNxt = '0;
            stateNxt  = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              stateNxt  = ST_RD_ACK;
              bitCntNxt = '0;
            end else begin
              stb.shiftTx = 1'b1;
              bitCntNxt   = bitCnt + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) masterAckNxt = ~sdaS;
          if (sclFall) begin
            if (masterAck) begin
              stb.loadTx = 1'b1;
              stateNxt   = ST_RDATA;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      rwBit     <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stateNxt;
      bitCnt    <= bitCntNxt;
      rwBit     <= rwBitNxt;
      masterAck <= masterAckNxt;
    end
  end

  assign sdaPullLow = ackState | ((state == ST_RDATA) & ~txMsb);

endmodule

// File: rtl/i2cRegMem.sv
module i2cRegMem
  import i2cMemPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int MEM_DEPTH   = 256,
  parameter int PAGE_BYTES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaPullLow
);

  localparam int ADDR_W    = $clog2(MEM_DEPTH);
  localparam int PAGE_BITS = $clog2(PAGE_BYTES);

  logic sclSync, sdaSync, sclRise, sclFall, startDet, stopDet;
  logic [BYTE_W-1:0] rxByte;
  logic txMsb;
  logic [ADDR_W-1:0] wordPtr;
  pathStb_t ctlStb;

  i2cBusSense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclSync), .sdaS(sdaSync), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2cSlaveCtrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaS(sdaSync),
    .rxByte(rxByte), .txMsb(txMsb), .stb(ctlStb), .sdaPullLow(sdaPullLow)
  );

  i2cMemPath #(.MEM_DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE_BYTES)) u_path (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .sdaS(sdaSync),
    .rxByte(rxByte), .txMsb(txMsb), .wordPtr(wordPtr)
  );

endmodule

// File: rtl/i2cRegMemChk.sv
module i2cRegMemChk #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_BITS = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclS,
  input logic              sdaPullLow,
  input logic              startSeen,
  input logic              stopSeen,
  input logic              writeStb,
  input logic [ADDR_W-1:0] ptr
);

  logic inRst;
  always_ff @(posedge clk) inRst <= !rstN;

  always @(posedge clk) begin
    if (!rstN && inRst) begin
      AST_RESET_RELEASED: assert (!sdaPullLow) else $error("pull active in reset"); // R8
    end
  end

  AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPullLow != $past(sdaPullLow)) |-> !sclS); // R9

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> !sdaPullLow); // R1

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaPullLow); // R2

  AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    writeStb |=> (ptr[ADDR_W-1:PAGE_BITS] == $past(ptr[ADDR_W-1:PAGE_BITS])) &&
                 (ptr[PAGE_BITS-1:0] == $past(ptr[PAGE_BITS-1:0]) + PAGE_BITS'(1))); // R5

endmodule

bind i2cRegMem i2cRegMemChk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .sclS(sclSync), .sdaPullLow(sdaPullLow),
  .startSeen(startDet), .stopSeen(stopDet), .writeStb(ctlStb.writeByte),
  .ptr(wordPtr)
);

// File: tb/sim_i2cRegMem.sv
module sim_i2cRegMem;

  localparam int QTR = 10;  // system clocks per quarter bus-clock period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic sdaPull;
  wire  sdaLine = sdaDrv & ~sdaPull;

  always #4 clk = ~clk;

  i2cRegMem #(.DEV_ADDR(7'h50)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .sdaPullLow(sdaPull)
  );

  int nRun = 0;
  int nFail = 0;
  logic [7:0] wrBuf [16];
  logic [7:0] rdBuf [16];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; tick();
    sclDrv = 1'b1; tick();
    sdaDrv = 1'b0; tick();
    sclDrv = 1'b0; tick();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; tick();
    sclDrv = 1'b1; tick();
    sdaDrv = 1'b1; tick();
  endtask

  task automatic bitCycle(input logic b, output logic got);
    sdaDrv = b; tick();
    sclDrv = 1'b1; tick();
    got = sdaLine; tick();
    sclDrv = 1'b0; tick();
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic g;
    for (int i = 7; i >= 0; i--) bitCycle(d[i], g);
    bitCycle(1'b1, g);
    ack = ~g;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] d);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(1'b1, g);
      d[i] = g;
    end
    bitCycle(~giveAck, g);
  endtask

  task automatic writeSeq(input logic [7:0] wa, input int n);
    logic ack;
    busStart();
    sendByte(8'hA0, ack); check("R3 write address ack", ack, 1);
    sendByte(wa, ack);    check("R4 pointer byte ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(wrBuf[i], ack); check("R4 data byte ack", ack, 1);
    end
    busStop();
  endtask

  task automatic readSeq(input logic [7:0] wa, input int n);
    logic ack;
    busStart();
    sendByte(8'hA0, ack); check("R3 address ack before read", ack, 1);
    sendByte(wa, ack);    check("R4 pointer ack before read", ack, 1);
    busStart();
    sendByte(8'hA1, ack); check("R6 read address ack", ack, 1);
    for (int i = 0; i < n; i++) recvByte(i != n - 1, rdBuf[i]);
    tick();
    check("R7 released after not-acknowledge", sdaPull, 0);
    busStop();
  endtask

  task automatic testReset();
    check("R8 released in reset", sdaPull, 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    check("R8 released after reset", sdaPull, 0);
  endtask

  task automatic testWriteRead();
    wrBuf[0] = 8'h11; wrBuf[1] = 8'h22; wrBuf[2] = 8'h33;
    writeSeq(8'h10, 3);
    readSeq(8'h10, 3);
    check("R6 read byte 0", rdBuf[0], 8'h11);
    check("R6 R7 read byte 1 after ack", rdBuf[1], 8'h22);
    check("R6 R7 read byte 2 after ack", rdBuf[2], 8'h33);
  endtask

  task automatic testWrongAddr();
    logic ack;
    busStart();
    sendByte(8'hA2, ack); check("R3 foreign address not acked", ack, 0);
    sendByte(8'h10, ack); check("R3 ignored byte not acked", ack, 0);
    sendByte(8'h99, ack); check("R3 ignored data not acked", ack, 0);
    busStop();
    readSeq(8'h10, 1);
    check("R3 memory untouched by foreign write", rdBuf[0], 8'h11);
  endtask

  task automatic testPageWrap();
    logic ack;
    wrBuf[0] = 8'h5A; wrBuf[1] = 8'h3C;
    writeSeq(8'h28, 2);
    for (int i = 0; i < 9; i++) wrBuf[i] = 8'hA0 + 8'(i);
    writeSeq(8'h20, 9);
    readSeq(8'h20, 9);
    check("R5 ninth byte overwrites page start", rdBuf[0], 8'hA8);
    for (int i = 1; i < 8; i++) check("R5 page byte kept", rdBuf[i], 8'hA0 + 8'(i));
    check("R5 R6 next page untouched, read crosses page", rdBuf[8], 8'h5A);
    busStart();
    sendByte(8'hA1, ack); check("R6 current-address read ack", ack, 1);
    recvByte(1'b0, rdBuf[0]);
    busStop();
    check("R6 pointer kept after read", rdBuf[0], 8'h3C);
    wrBuf[0] = 8'hC1; wrBuf[1] = 8'hC2; wrBuf[2] = 8'hC3;
    writeSeq(8'h36, 3);
    readSeq(8'h30, 1);
    check("R5 unaligned burst wraps to page start", rdBuf[0], 8'hC3);
    readSeq(8'h36, 2);
    check("R5 unaligned burst first byte", rdBuf[0], 8'hC1);
    check("R5 unaligned burst second byte", rdBuf[1], 8'hC2);
  endtask

  task automatic testStopIgnore();
    logic ack;
    sclDrv = 1'b0; tick();
    sendByte(8'hA0, ack);
    check("R2 bits after stop not acked", ack, 0);
    sendByte(8'h10, ack);
    check("R2 second byte after stop not acked", ack, 0);
    sdaDrv = 1'b0; tick();
    sclDrv = 1'b1; tick();
    sdaDrv = 1'b1; tick();
    readSeq(8'h10, 1);
    check("R2 nothing stored after stop", rdBuf[0], 8'h11);
  endtask

  task automatic testRestartMidByte();
    logic ack;
    logic g;
    busStart();
    sendByte(8'hA0, ack);
    sendByte(8'h40, ack);
    bitCycle(1'b1, g); bitCycle(1'b0, g); bitCycle(1'b1, g); bitCycle(1'b0, g);
    busStart();
    sendByte(8'hA0, ack); check("R1 address acked after mid-byte start", ack, 1);
    sendByte(8'h40, ack); check("R1 pointer acked after mid-byte start", ack, 1);
    sendByte(8'h77, ack); check("R1 data acked after mid-byte start", ack, 1);
    busStop();
    readSeq(8'h40, 1);
    check("R1 byte stored after resynchronised frame", rdBuf[0], 8'h77);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (10) @(negedge clk);
    testReset();
    testWriteRead();
    testWrongAddr();
    testPageWrap();
    testStopIgnore();
    testRestartMidByte();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule